// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. It spots the one dependency that bypassing cannot cover: a memory load in execute whose destination register is read by the instruction now in decode. When it finds one, it freezes the program counter and the fetch/decode register for one cycle. It also turns the control word entering the decode/execute register into all zeros, so one empty slot goes down the pipe in its place.

The stall is combinational, computed from the registers' current contents. It drops by itself once the load has left execute. After that single cycle, normal bypassing supplies the loaded value. The load and everything older than it keep moving during the stall.

The project includes a small model of the program counter, the fetch/decode register and the control half of the decode/execute register, so the stall can be observed over time. Instruction memory and the instruction decoder stay outside the block: the fetched word and the decoded control word arrive on ports.

Top module: `lu_stall_ctrl`

## Requirements
- R1: A stall is raised exactly when the registered execute control word has its memory-read bit (bit 2) set and the execute instruction's target field (bits 20:16) equals either the decode instruction's first source field (bits 25:21) or its second source field (bits 20:16).
- R2: During a stall the program counter keeps its value. Otherwise it advances by 4 on every clock edge.
- R3: During a stall the fetch/decode register keeps its instruction. Otherwise it captures the fetched word.
- R4: During a stall the control word written into the decode/execute register is all zeros. The instruction word still passes through unchanged.
- R5: The program counter write enable and the fetch/decode write enable are both the inverse of the stall, and the bubble select equals the stall.
- R6: A stall lasts one cycle for each dependent load. The cycle after it carries no stall unless another load is in execute.
- R7: An instruction in execute that matches a source register but does not read memory causes no stall.
- R8: A synchronous active-low reset clears the program counter, the fetch/decode instruction and the decode/execute control word and instruction. No stall is raised out of reset.
- R9: The control word layout is: execute fields in bits 8:5, memory fields in bits 4:2 (bit 2 = memory read), writeback fields in bits 1:0. A load advances into the decode/execute register with its control word intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_instr_i | input | 32 | Instruction word fetched at the current program counter |
| dec_ctrl_i | input | 9 | Control word decoded from the fetch/decode instruction |
| pc_o | output | 32 | Program counter |
| pc_write_o | output | 1 | Program counter write enable |
| ifid_write_o | output | 1 | Fetch/decode register write enable |
| bubble_sel_o | output | 1 | Selects the zero control word into decode/execute |
| ifid_instr_o | output | 32 | Instruction held in the fetch/decode register |
| idex_ctrl_o | output | 9 | Control word held in the decode/execute register |
| idex_instr_o | output | 32 | Instruction held in the decode/execute register |

## Verification
The embedded assertions check on every cycle that a stall freezes the program counter and the fetch/decode register, that it is followed by a zero control word in decode/execute, and that it never lasts two cycles in a row. Only the bench scenarios can show the end-to-end pattern that a load and its dependant produce: the program counter repeating exactly once, one bubble in the stream, and no stall at all for matches against a non-load producer or for instructions that follow an unrelated load. The bench also shows that an instruction word travels on through the bubble slot and that a reset taken mid-run returns the pipeline to an empty state.

// File: rtl/lu_hazard_pkg.sv
// Shared types and constants for the load-use stall controller.
// Assumes a 32-bit instruction word with two 5-bit source fields.
package lu_hazard_pkg;
    localparam int XLEN    = 32;
    localparam int RIDX_W  = 5;
    localparam int SRC1_LSB = 21;
    localparam int SRC2_LSB = 16;
    localparam int PC_STEP = 4;

    typedef struct packed {
        logic       reg_dst;
        logic       alu_src;
        logic [1:0] alu_op;
    } ex_ctrl_t;

    typedef struct packed {
        logic branch;
        logic mem_write;
        logic mem_read;
    } mem_ctrl_t;

    typedef struct packed {
        logic mem_to_reg;
        logic reg_write;
    } wb_ctrl_t;

    typedef struct packed {
        ex_ctrl_t  ex;
        mem_ctrl_t mem;
        wb_ctrl_t  wb;
    } stage_ctrl_t;

    localparam int CTRL_W = $bits(stage_ctrl_t);
endpackage

// File: rtl/lu_detect.sv
// Load-use comparator: flags a stall when the execute-stage load targets
// a register that either decode-stage source field names.
// Assumes fields arrive already extracted; purely combinational.
module lu_detect #(
    parameter int RIDX_W = 5,
    parameter int NSRC   = 2
) (
    input  logic                           ex_mem_read,
    input  logic [RIDX_W-1:0]              ex_dst,
    input  logic [NSRC-1:0][RIDX_W-1:0]    id_src,
    output logic                           stall
);
    logic [NSRC-1:0] hit;

    // One equality comparator per decode source field.
    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign hit[s] = (id_src[s] == ex_dst);
    end

    // Stall only when the producer in execute is a load.
    always_comb begin
        stall = ex_mem_read && (|hit);
    end
endmodule

// File: rtl/lu_pc_reg.sv
// Program counter with write enable; steps by STEP when enabled.
// Assumes reset vector zero and no branch redirection.
module lu_pc_reg #(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    output logic [XLEN-1:0] pc_q
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    // Advance or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_we) pc_q <= pc_q + STEP_V;
    end

    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> (pc_q == $past(pc_q)));
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && $past(rst_n)) |=> (pc_q == $past(pc_q) + STEP_V));
endmodule

// File: rtl/lu_ifid_reg.sv
// Fetch/decode instruction register with write enable.
// Assumes an empty (all-zero) word stands for no instruction.
module lu_ifid_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] instr_d,
    output logic [XLEN-1:0] instr_q
);
    // Capture the fetched word unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)  instr_q <= '0;
        else if (we) instr_q <= instr_d;
    end

    a_r3_ifid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(instr_q));
endmodule

// File: rtl/lu_idex_reg.sv
// Decode/execute register: control word through a bubble mux, plus the
// instruction word, which is always copied. Assumes zero control = no-op.
module lu_idex_reg #(
    parameter int XLEN = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bubble,
    input  lu_hazard_pkg::stage_ctrl_t  ctrl_d,
    input  logic [XLEN-1:0]             instr_d,
    output lu_hazard_pkg::stage_ctrl_t  ctrl_q,
    output logic [XLEN-1:0]             instr_q
);
    import lu_hazard_pkg::*;
    stage_ctrl_t ctrl_mux;

    // Replace every control field with zero when a bubble is requested.
    always_comb begin
        ctrl_mux = bubble ? stage_ctrl_t'('0) : ctrl_d;
    end

    // Register the control word and the instruction each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            instr_q <= '0;
        end else begin
            ctrl_q  <= ctrl_mux;
            instr_q <= instr_d;
        end
    end

    a_r4_bubble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (ctrl_q == '0));
    a_r4_instr_passes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (instr_q == $past(instr_d)));
endmodule

// File: rtl/lu_stall_ctrl.sv
// Load-use stall controller top: detection plus PC, IF/ID and ID/EX
// control model. Assumes decoding of the IF/ID word happens outside
// and returns on dec_ctrl_i in the same cycle.
module lu_stall_ctrl #(
    parameter int XLEN     = lu_hazard_pkg::XLEN,
    parameter int RIDX_W   = lu_hazard_pkg::RIDX_W,
    parameter int SRC1_LSB = lu_hazard_pkg::SRC1_LSB,
    parameter int SRC2_LSB = lu_hazard_pkg::SRC2_LSB,
    parameter int PC_STEP  = lu_hazard_pkg::PC_STEP,
    parameter int CTRL_W   = lu_hazard_pkg::CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   fetch_instr_i,
    input  logic [CTRL_W-1:0] dec_ctrl_i,
    output logic [XLEN-1:0]   pc_o,
    output logic              pc_write_o,
    output logic              ifid_write_o,
    output logic              bubble_sel_o,
    output logic [XLEN-1:0]   ifid_instr_o,
    output logic [CTRL_W-1:0] idex_ctrl_o,
    output logic [XLEN-1:0]   idex_instr_o
);
    import lu_hazard_pkg::*;
    localparam int NSRC = 2;

    stage_ctrl_t                     idex_ctrl;
    logic                            stall;
    logic [NSRC-1:0][RIDX_W-1:0]     id_src;
    logic [RIDX_W-1:0]               ex_dst;

    // Extract register fields from the two pipeline registers.
    always_comb begin
        id_src[0] = ifid_instr_o[SRC1_LSB +: RIDX_W];
        id_src[1] = ifid_instr_o[SRC2_LSB +: RIDX_W];
        ex_dst    = idex_instr_o[SRC2_LSB +: RIDX_W];
    end

    lu_detect #(.RIDX_W(RIDX_W), .NSRC(NSRC)) detect_i (
        .ex_mem_read (idex_ctrl.mem.mem_read),
        .ex_dst      (ex_dst),
        .id_src      (id_src),
        .stall       (stall)
    );

    // Fan the stall out to the three pipeline controls.
    always_comb begin
        pc_write_o   = !stall;
        ifid_write_o = !stall;
        bubble_sel_o = stall;
    end

    lu_pc_reg #(.XLEN(XLEN), .STEP(PC_STEP)) pc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pc_we (pc_write_o),
        .pc_q  (pc_o)
    );

    lu_ifid_reg #(.XLEN(XLEN)) ifid_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ifid_write_o),
        .instr_d (fetch_instr_i),
        .instr_q (ifid_instr_o)
    );

    lu_idex_reg #(.XLEN(XLEN)) idex_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bubble  (bubble_sel_o),
        .ctrl_d  (stage_ctrl_t'(dec_ctrl_i)),
        .instr_d (ifid_instr_o),
        .ctrl_q  (idex_ctrl),
        .instr_q (idex_instr_o)
    );

    // Present the registered control word as a flat vector.
    always_comb begin
        idex_ctrl_o = idex_ctrl;
    end

    a_r6_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    a_r5_enables_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write_o == ifid_write_o) && (bubble_sel_o == !pc_write_o));
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && idex_ctrl_o == '0 && ifid_instr_o == '0));
endmodule

// File: tb/lu_stall_ctrl_tb_top.sv
module lu_stall_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_instr;
    logic [8:0]  dec_ctrl;
    logic [31:0] pc, ifid_instr, idex_instr;
    logic        pc_write, ifid_write, bubble_sel;
    logic [8:0]  idex_ctrl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lu_stall_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_instr_i(fetch_instr), .dec_ctrl_i(dec_ctrl),
        .pc_o(pc), .pc_write_o(pc_write), .ifid_write_o(ifid_write),
        .bubble_sel_o(bubble_sel), .ifid_instr_o(ifid_instr),
        .idex_ctrl_o(idex_ctrl), .idex_instr_o(idex_instr)
    );

    function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] imem(input logic [31:0] addr);
        case (addr[31:2])
            30'd0: return itype(6'h23, 1, 2, 20);   // lw r2
            30'd1: return rtype(2, 5, 4, 6'h24);    // and r4,r2,r5
            30'd2: return rtype(6, 7, 8, 6'h25);    // or r8,r6,r7
            30'd3: return rtype(4, 2, 9, 6'h20);    // add r9,r4,r2
            30'd4: return itype(6'h23, 6, 3, 0);    // lw r3
            30'd5: return rtype(7, 3, 10, 6'h22);   // sub r10,r7,r3
            30'd6: return rtype(3, 3, 11, 6'h20);   // add r11,r3,r3
            30'd7: return itype(6'h23, 1, 12, 0);   // lw r12
            30'd8: return rtype(1, 1, 13, 6'h20);   // add r13,r1,r1
            30'd9: return rtype(1, 0, 15, 6'h24);   // and r15,r1,r0
            default: return 32'd0;
        endcase
    endfunction

    // Layout {ex[3:0], mem{branch,mem_write,mem_read}, wb{mem_to_reg,reg_write}}
    function automatic logic [8:0] decode(input logic [31:0] w);
        if (w == 32'd0)            return 9'd0;
        else if (w[31:26] == 6'h23) return {4'b0100, 3'b001, 2'b11};
        else                        return {4'b1010, 3'b000, 2'b01};
    endfunction

    assign fetch_instr = imem(pc);
    assign dec_ctrl    = decode(ifid_instr);

    // Expected per edge after reset: {pc, stall, idex control zero}
    localparam int NVEC = 12;
    localparam logic [33:0] VEC [0:NVEC-1] = '{
        {32'd4,  1'b0, 1'b1}, {32'd8,  1'b1, 1'b0}, {32'd8,  1'b0, 1'b1},
        {32'd12, 1'b0, 1'b0}, {32'd16, 1'b0, 1'b0}, {32'd20, 1'b0, 1'b0},
        {32'd24, 1'b1, 1'b0}, {32'd24, 1'b0, 1'b1}, {32'd28, 1'b0, 1'b0},
        {32'd32, 1'b0, 1'b0}, {32'd36, 1'b0, 1'b0}, {32'd40, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int holds;
        int bubbles;
        holds = 0;
        bubbles = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk("R8 pc", pc, 32'd0);
        chk("R8 ifid", ifid_instr, 32'd0);
        chk("R8 idex ctrl", {23'd0, idex_ctrl}, 32'd0);
        chk("R8 no stall", {31'd0, bubble_sel}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R2 pc edge %0d", i + 1), pc, VEC[i][33:2]);
            chk($sformatf("R1 R6 stall edge %0d", i + 1), {31'd0, bubble_sel}, {31'd0, VEC[i][1]});
            chk($sformatf("R5 enables edge %0d", i + 1), {30'd0, pc_write, ifid_write},
                {30'd0, !VEC[i][1], !VEC[i][1]});
            chk($sformatf("R4 idex zero edge %0d", i + 1), {31'd0, idex_ctrl == 9'd0}, {31'd0, VEC[i][0]});
            if (!pc_write) holds++;
            if (idex_ctrl == 9'd0 && i > 0) bubbles++;
            if (i == 1) begin
                chk("R9 load ctrl in idex", {23'd0, idex_ctrl}, {23'd0, 4'b0100, 3'b001, 2'b11});
                chk("R3 ifid has and", ifid_instr, imem(32'd4));
            end
            if (i == 2) begin
                chk("R3 ifid held", ifid_instr, imem(32'd4));
                chk("R4 instr through bubble", idex_instr, imem(32'd4));
            end
            if (i == 11) chk("R7 non-load match", {31'd0, bubble_sel}, 32'd0);
        end
        chk("R6 pc repeats twice total", holds, 2);
        chk("R6 one bubble per load-use", bubbles, 2);
        // R8: reset taken during a stall
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); // edge1 again
        @(posedge clk); // edge2: stall cycle
        @(negedge clk);
        chk("R1 stall after rerun", {31'd0, bubble_sel}, 32'd1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 mid-run pc", pc, 32'd0);
        chk("R8 mid-run idex ctrl", {23'd0, idex_ctrl}, 32'd0);
        chk("R8 mid-run idex instr", idex_instr, 32'd0);
        chk("R8 mid-run ifid", ifid_instr, 32'd0);
        chk("R8 mid-run no stall", {31'd0, pc_write}, 32'd1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule